// File: doc/BRIEF.md
# Modem Handshake Control and Status Register

This block holds the register logic for the handshake lines of an asynchronous serial port. A control register, written by the host with a one-cycle strobe, drives four active-low handshake outputs (terminal ready, request to send and two general-purpose outputs). A fifth bit in the same register selects a diagnostic loopback.

A status register reports the asserted state of four active-low handshake inputs: clear to send, data set ready, ring indicator and carrier detect. It also holds four sticky change flags. A one-cycle host read strobe clears the flags. A modem-status interrupt request is raised whenever any flag is set and the interrupt source is enabled.

In loopback the output pins are held at their inactive high level. The four status lines are then taken from the control bits instead of the pins, so that software can exercise the change flags and the interrupt without external wiring. Bus address decode and interrupt prioritisation belong to the surrounding port.

Top module: `modem_ctl_stat`

## Requirements
- R1: While `rst` is high, `ctl_rdata` reads 0, all four handshake outputs are 1, the change flags `sts_rdata[3:0]` are 0 and `msint` is 0.
- R2: A write sets the control register from `ctl_wdata[4:0]`. When loopback is off, set bit 0 drives `dtr_n` low, bit 1 drives `rts_n` low, bit 2 drives `out1_n` low and bit 3 drives `out2_n` low. Bits 7..5 are ignored on write and read back as 0.
- R3: When loopback is off, `sts_rdata[7:4]` equal the inverted `cd_n, ri_n, dsr_n, cts_n` (bit 7 = CD, bit 6 = RI, bit 5 = DSR, bit 4 = CTS). They follow a pin change after two clock edges of synchronisation.
- R4: Flag bits 0 (CTS), 1 (DSR) and 3 (CD) are set by any change of the matching status line. The flag is visible after the third clock edge following a pin change.
- R5: Flag bit 2 is set only when `ri_n` goes from 0 to 1 (RI status bit falling). A 1-to-0 change of `ri_n` sets no flag.
- R6: `sts_rdata` returns the flags as they stand during the `sts_rd` cycle, and all four flags are cleared at the end of that cycle. If a change is detected on the same edge, the new flag stays set.
- R7: `msint` is 1 exactly when `irq_en` is 1 and at least one flag is set.
- R8: With control bit 4 set, all four handshake outputs are 1. Status bits 4, 5, 6 and 7 then equal control bits 1, 0, 2 and 3, and the input pins have no effect on `sts_rdata`. In loopback a control write reaches the status lines on the following edge, and the flags follow one edge later.
- R9: After reset is released, no flag is set during the first three clock edges, whatever the input pin levels are.
- R10: A set flag stays set until a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| ctl_wr | input | 1 | One-cycle control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read-back |
| sts_rd | input | 1 | One-cycle status read strobe; clears the change flags |
| sts_rdata | output | 8 | Status: line states [7:4], change flags [3:0] |
| irq_en | input | 1 | Modem-status interrupt enable |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| dsr_n | input | 1 | Data set ready, active low, asynchronous |
| ri_n | input | 1 | Ring indicator, active low, asynchronous |
| cd_n | input | 1 | Carrier detect, active low, asynchronous |
| dtr_n | output | 1 | Terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| out1_n | output | 1 | General-purpose output 1, active low |
| out2_n | output | 1 | General-purpose output 2, active low |
| msint | output | 1 | Modem-status interrupt request |

## Verification
The properties assume that the host strobes are single-cycle pulses and that `rst` is high from time zero. They also assume the handshake pins hold each level long enough to pass the two-flop synchroniser. The ring-indicator property also assumes the pins move no faster than one change per cycle.

The stimulus respects these assumptions. Pins, strobes and the enable are driven only at falling clock edges. Each pin pattern is held for at least three cycles before it is read. In loopback, the status lines change only through control writes spaced apart by read strobes.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int DATA_W  = 8;
  localparam int NLINES  = 4;
  // status line order
  localparam int L_CTS   = 0;
  localparam int L_DSR   = 1;
  localparam int L_RI    = 2;
  localparam int L_CD    = 3;
  // control bit positions
  localparam int C_DTR   = 0;
  localparam int C_RTS   = 1;
  localparam int C_OUT1  = 2;
  localparam int C_OUT2  = 3;
  localparam int C_LOOP  = 4;
  localparam int CTRL_W  = 5;
  // lines whose flag fires only when the active-high line falls
  localparam logic [NLINES-1:0] FALL_ONLY = 4'b0100;
endpackage

// File: rtl/mcs_sync.sv
module mcs_sync #(
  parameter int WIDTH   = 4,
  parameter int STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or posedge rst) begin
        if (rst) stg[s] <= {WIDTH{RST_VAL}};
        else if (s == 0) stg[s] <= d_async;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/mcs_ctrl_reg.sv
module mcs_ctrl_reg
  import modem_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              loop_en,
  output logic [NLINES-1:0] loop_src,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              out1_n,
  output logic              out2_n
);
  logic [CTRL_W-1:0] ctrl;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)     ctrl <= '0;
    else if (wr) ctrl <= wdata;
  end

  assign rdata   = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
  assign loop_en = ctrl[C_LOOP];

  // loopback wiring: CTS<-RTS, DSR<-DTR, RI<-OUT1, CD<-OUT2
  always_comb begin
    loop_src        = '0;
    loop_src[L_CTS] = ctrl[C_RTS];
    loop_src[L_DSR] = ctrl[C_DTR];
    loop_src[L_RI]  = ctrl[C_OUT1];
    loop_src[L_CD]  = ctrl[C_OUT2];
  end

  // pins parked inactive (high) while looped back
  assign dtr_n  = loop_en | ~ctrl[C_DTR];
  assign rts_n  = loop_en | ~ctrl[C_RTS];
  assign out1_n = loop_en | ~ctrl[C_OUT1];
  assign out2_n = loop_en | ~ctrl[C_OUT2];
endmodule

// File: rtl/mcs_delta.sv
module mcs_delta #(
  parameter int NL = 4,
  parameter logic [NL-1:0] FALL_MASK = '0,
  parameter int SETTLE = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NL-1:0] line,
  input  logic          clr,
  output logic [NL-1:0] delta
);
  localparam int CW = $clog2(SETTLE + 1);

  logic [CW-1:0]  settle_cnt;
  logic           armed;
  logic [NL-1:0]  prev;
  logic [NL-1:0]  hit;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)         settle_cnt <= '0;
    else if (!armed) settle_cnt <= settle_cnt + 1'b1;
  end
  assign armed = (settle_cnt == CW'(SETTLE));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) prev <= '0;
    else     prev <= line;
  end

  generate
    for (genvar i = 0; i < NL; i++) begin : g_line
      if (FALL_MASK[i]) begin : g_fall
        assign hit[i] = armed & prev[i] & ~line[i];
      end else begin : g_any
        assign hit[i] = armed & (prev[i] ^ line[i]);
      end
      always_ff @(posedge clk or posedge rst) begin
        if (rst)         delta[i] <= 1'b0;
        else if (hit[i]) delta[i] <= 1'b1;
        else if (clr)    delta[i] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
  import modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       sts_rd,
  output logic [7:0] sts_rdata,
  input  logic       irq_en,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       cd_n,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       out1_n,
  output logic       out2_n,
  output logic       msint
);
  localparam int SETTLE = SYNC_STAGES + 1;

  logic [NLINES-1:0] pin_raw, pin_s, loop_src, line, delta;
  logic              loop_en;
  logic [2:0]        unused_wr_hi;

  assign unused_wr_hi = ctl_wdata[7:5];

  always_comb begin
    pin_raw        = '1;
    pin_raw[L_CTS] = cts_n;
    pin_raw[L_DSR] = dsr_n;
    pin_raw[L_RI]  = ri_n;
    pin_raw[L_CD]  = cd_n;
  end

  mcs_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk(clk), .rst(rst), .d_async(pin_raw), .q_sync(pin_s)
  );

  mcs_ctrl_reg i_ctrl (
    .clk(clk), .rst(rst), .wr(ctl_wr), .wdata(ctl_wdata[CTRL_W-1:0]),
    .rdata(ctl_rdata), .loop_en(loop_en), .loop_src(loop_src),
    .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n)
  );

  assign line = loop_en ? loop_src : ~pin_s;

  mcs_delta #(.NL(NLINES), .FALL_MASK(FALL_ONLY), .SETTLE(SETTLE)) i_delta (
    .clk(clk), .rst(rst), .line(line), .clr(sts_rd), .delta(delta)
  );

  assign sts_rdata = {line, delta};
  assign msint     = irq_en & (|delta);
endmodule

// File: rtl/modem_ctl_stat_chk.sv
module modem_ctl_stat_chk (
  input logic       clk,
  input logic       rst,
  input logic       ctl_wr,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_rdata,
  input logic       sts_rd,
  input logic [7:0] sts_rdata,
  input logic       irq_en,
  input logic       cts_n,
  input logic       dsr_n,
  input logic       ri_n,
  input logic       cd_n,
  input logic       dtr_n,
  input logic       rts_n,
  input logic       out1_n,
  input logic       out2_n,
  input logic       msint
);
  // R2
  ctl_write_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (ctl_rdata == {3'b000, $past(ctl_wdata[4:0])}));

  // R8
  loop_park_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_rdata[4] |-> ({dtr_n, rts_n, out1_n, out2_n} == 4'hF));

  // R5
  ri_fall_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_rdata[2]) |-> (!$past(sts_rdata[6]) && $past(sts_rdata[6], 2)));

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !sts_rd |=> ((sts_rdata[3:0] & $past(sts_rdata[3:0])) == $past(sts_rdata[3:0])));

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    msint |-> (irq_en && (sts_rdata[3:0] != 4'h0)));
endmodule

bind modem_ctl_stat modem_ctl_stat_chk i_chk (.*);

// File: tb/test_modem_ctl_stat.sv
`timescale 1ns/1ps
module test_modem_ctl_stat;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic       sts_rd = 1'b0;
  logic [7:0] sts_rdata;
  logic       irq_en = 1'b1;
  logic [3:0] in_n = 4'h0; // {cd_n, ri_n, dsr_n, cts_n}
  logic       dtr_n, rts_n, out1_n, out2_n, msint;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  modem_ctl_stat i_modem_ctl_stat (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .sts_rd(sts_rd), .sts_rdata(sts_rdata),
    .irq_en(irq_en), .cts_n(in_n[0]), .dsr_n(in_n[1]), .ri_n(in_n[2]),
    .cd_n(in_n[3]), .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n),
    .out2_n(out2_n), .msint(msint)
  );

  // {in_n[3:0], expected sts_rdata} starting from all lines inactive
  localparam logic [11:0] VEC [0:7] = '{
    {4'b1110, 8'h11}, {4'b1100, 8'h32}, {4'b1000, 8'h70}, {4'b1100, 8'h34},
    {4'b0100, 8'hB8}, {4'b1111, 8'h0B}, {4'b0000, 8'hFB}, {4'b1111, 8'h0F}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    ctl_wr = 1'b1; ctl_wdata = d; tick(1); ctl_wr = 1'b0;
  endtask

  task automatic rd_clear();
    sts_rd = 1'b1; tick(1); sts_rd = 1'b0;
  endtask

  function automatic logic [7:0] pins();
    return {4'h0, out2_n, out1_n, rts_n, dtr_n};
  endfunction

  initial begin
    tick(3);
    // R1 reset state
    chk("R1 ctl", ctl_rdata, 8'h00);
    chk("R1 pins", pins(), 8'h0F);
    chk("R1 flags", {4'h0, sts_rdata[3:0]}, 8'h00);
    chk("R1 irq", {7'h0, msint}, 8'h00);
    rst = 1'b0;
    tick(2);
    // R3 R9 lines asserted through sync, no flag in settle window
    chk("R9 settle", sts_rdata, 8'hF0);
    tick(4);
    chk("R9 quiet", sts_rdata, 8'hF0);
    chk("R9 irq", {7'h0, msint}, 8'h00);
    in_n = 4'hF; tick(3);
    chk("R4 R5 release", sts_rdata, 8'h0F);
    rd_clear();
    chk("R6 cleared", sts_rdata, 8'h00);

    for (int i = 0; i < 8; i++) begin
      in_n = VEC[i][11:8]; tick(3);
      chk($sformatf("R3 R4 R5 vec%0d", i), sts_rdata, VEC[i][7:0]);
      chk($sformatf("R7 vec%0d", i), {7'h0, msint}, {7'h0, VEC[i][3:0] != 4'h0});
      rd_clear();
      chk($sformatf("R6 vec%0d", i), {4'h0, sts_rdata[3:0]}, 8'h00);
    end

    // R2 control drive and ignored high bits
    wr(8'h05);
    chk("R2 rd", ctl_rdata, 8'h05);
    chk("R2 pins", pins(), 8'h0A);
    wr(8'hEA);
    chk("R2 hi ignored", ctl_rdata, 8'h0A);
    chk("R2 pins b", pins(), 8'h05);

    // R10 sticky, R7 enable
    in_n = 4'b1110; tick(3);
    tick(5);
    chk("R10 sticky", sts_rdata, 8'h11);
    irq_en = 1'b0; tick(1);
    chk("R7 masked", {7'h0, msint}, 8'h00);
    irq_en = 1'b1; tick(1);
    chk("R7 enabled", {7'h0, msint}, 8'h01);
    rd_clear();
    chk("R7 after read", {7'h0, msint}, 8'h00);

    // R8 loopback
    wr(8'h1A);
    chk("R8 park", pins(), 8'h0F);
    chk("R8 lines", {sts_rdata[7:4], 4'h0}, 8'h90);
    tick(2); rd_clear();
    wr(8'h1F); tick(1);
    chk("R8 R5 loop rise", sts_rdata, 8'hF2);
    rd_clear();
    in_n = 4'h0; tick(4);
    chk("R8 pins ignored", sts_rdata, 8'hF0);
    // R6 read coinciding with a detected change
    ctl_wr = 1'b1; ctl_wdata = 8'h1B; tick(1);
    ctl_wr = 1'b0; sts_rd = 1'b1;
    chk("R6 read value", sts_rdata, 8'hB0);
    tick(1); sts_rd = 1'b0;
    chk("R6 set wins", sts_rdata, 8'hB4);
    rd_clear();
    wr(8'h00); tick(3);
    chk("R2 loop off pins", pins(), 8'h0F);
    rd_clear();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule